// File: doc/BRIEF.md
# Windowed Subsampling Pixel Readout Sequencer

This block produces the address sequence used to read a rectangular window out of a large image sensor, one pixel address per clock. The caller supplies a window origin, a width, a height and a scale bit, then pulses a start strobe. The block walks the window in row-major order and emits a valid-qualified row/column address stream, marking the first retained pixel with `sof_o` and the last with `eof_o`. Pixels outside the window are never addressed, so readout time depends only on how many pixels are kept.

In half-scale mode the sequencer keeps the first, third, fifth and later columns of the first, third, fifth and later rows of the window, counted from the window's own origin. This cuts readout to about a quarter of the full-scale time for the same window. Any window that runs past the sensor edge is clipped at that edge. The number of retained pixels in each direction is capped at `OUT_DIM`, so every window fits the square tile that a downstream processing array consumes. Configuration is sampled only on an accepted strobe.

Top module: `roi_scan_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released, `busy_o`, `pix_valid_o`, `sof_o` and `eof_o` are 0 until a start is accepted.
- R2: A start is accepted when `start_i` is 1 at a rising edge while `busy_o` is 0 and the window keeps at least one pixel. From the next cycle on, `busy_o` and `pix_valid_o` are 1 and one pixel address is presented per cycle with no gaps, in row-major order.
- R3: With `half_scale_i`=0, every row from `org_row_i` to `org_row_i`+rows−1 is visited, and in each row the columns run from `org_col_i` to `org_col_i`+cols−1.
- R4: With `half_scale_i`=1, rows and columns advance in steps of 2 from the origin. The origin row and column are always kept, and the kept count per direction is ceil(extent/2).
- R5: The extent in each direction is the lesser of the requested size and the distance from the origin to the sensor edge (`SENSOR_W` − `org_col_i`, `SENSOR_H` − `org_row_i`). No emitted address lies outside the sensor.
- R6: The kept count per direction is limited to `OUT_DIM`. Pixels beyond that count are dropped from the far side of the window.
- R7: `sof_o` is 1 only with the first emitted pixel and `eof_o` only with the last. A one-pixel window raises both in the same cycle.
- R8: `busy_o` falls in the cycle after `eof_o`. A strobe received while `busy_o` is 1 has no effect on the ongoing sequence.
- R9: A strobe whose window keeps no pixel (zero width or height, or an origin at or beyond the sensor edge) is ignored, and `busy_o` stays 0.
- R10: The number of valid cycles in a readout equals kept rows × kept columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, samples configuration when idle |
| org_col_i | input | COL_W | Window origin column |
| org_row_i | input | ROW_W | Window origin row |
| win_w_i | input | COL_W | Requested window width in sensor pixels |
| win_h_i | input | ROW_W | Requested window height in sensor pixels |
| half_scale_i | input | 1 | 1 = keep every second row and column |
| busy_o | output | 1 | Readout in progress |
| pix_valid_o | output | 1 | Address outputs carry a pixel this cycle |
| pix_row_o | output | ROW_W | Row address of the pixel |
| pix_col_o | output | COL_W | Column address of the pixel |
| sof_o | output | 1 | First pixel of the window |
| eof_o | output | 1 | Last pixel of the window |

## Verification
A corrupted column or row counter shows up on the very next valid cycle as an address that breaks the step of 1 or 2 from its predecessor, or that falls outside the window. A wrong latched count appears within one row as a misplaced wrap or as a missing or extra `eof_o`. A busy flag that does not clear or that re-arms shows up one cycle after `eof_o` as a lingering `pix_valid_o`. The bench sweeps every origin column of a small sensor together with several widths, heights, origin rows and both scales, and compares every emitted address against an arithmetic model.

// File: rtl/roi_pkg.sv
package roi_pkg;
  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/roi_extent.sv
// Kept pixel count along one axis: clip at sensor edge, decimate, cap.
module roi_extent #(
  parameter int DIM     = 1280,
  parameter int AW      = 11,
  parameter int OUT_DIM = 128,
  parameter int CW      = 8
) (
  input  logic [AW-1:0] org_i,
  input  logic [AW-1:0] len_i,
  input  logic          half_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [AW:0] DimV = (AW+1)'(DIM);
  localparam logic [AW:0] CapV = (AW+1)'(OUT_DIM);

  logic [AW:0] org_w, len_w, rem, ext, kept;

  always_comb begin
    org_w = {1'b0, org_i};
    len_w = {1'b0, len_i};
    rem   = '0;
    ext   = '0;
    if (org_w < DimV) begin
      rem = DimV - org_w;
      ext = (len_w < rem) ? len_w : rem;
    end
    kept  = half_i ? ((ext + 1'b1) >> 1) : ext;
    cnt_o = (kept > CapV) ? CW'(CapV) : CW'(kept);
  end
endmodule

// File: rtl/roi_step_cnt.sv
// Index counter that wraps after the latched count.
module roi_step_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] idx_o,
  output logic          last_o
);
  assign last_o = (idx_o == cnt_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (load_i) idx_o <= '0;
    else if (adv_i)  idx_o <= last_o ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/roi_scan_ctrl.sv
module roi_scan_ctrl
  import roi_pkg::*;
#(
  parameter int SENSOR_W = 1280,
  parameter int SENSOR_H = 1024,
  parameter int OUT_DIM  = 128,
  parameter int COL_W    = clog2_min1(SENSOR_W),
  parameter int ROW_W    = clog2_min1(SENSOR_H)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] org_col_i,
  input  logic [ROW_W-1:0] org_row_i,
  input  logic [COL_W-1:0] win_w_i,
  input  logic [ROW_W-1:0] win_h_i,
  input  logic             half_scale_i,
  output logic             busy_o,
  output logic             pix_valid_o,
  output logic [ROW_W-1:0] pix_row_o,
  output logic [COL_W-1:0] pix_col_o,
  output logic             sof_o,
  output logic             eof_o
);
  localparam int CW = $clog2(OUT_DIM + 1);

  logic [CW-1:0]    ncol_d, nrow_d, ncol_q, nrow_q;
  logic [CW-1:0]    col_idx, row_idx;
  logic             col_last, row_last;
  logic [COL_W-1:0] org_col_q;
  logic [ROW_W-1:0] org_row_q;
  logic             half_q, busy_q, accept, done;

  roi_extent #(.DIM(SENSOR_W), .AW(COL_W), .OUT_DIM(OUT_DIM), .CW(CW)) u_col_ext (
    .org_i(org_col_i), .len_i(win_w_i), .half_i(half_scale_i), .cnt_o(ncol_d)
  );
  roi_extent #(.DIM(SENSOR_H), .AW(ROW_W), .OUT_DIM(OUT_DIM), .CW(CW)) u_row_ext (
    .org_i(org_row_i), .len_i(win_h_i), .half_i(half_scale_i), .cnt_o(nrow_d)
  );

  assign accept = start_i && !busy_q && (ncol_d != '0) && (nrow_d != '0);
  assign done   = busy_q && col_last && row_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      half_q    <= 1'b0;
      org_col_q <= '0;
      org_row_q <= '0;
      ncol_q    <= '0;
      nrow_q    <= '0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      half_q    <= half_scale_i;
      org_col_q <= org_col_i;
      org_row_q <= org_row_i;
      ncol_q    <= ncol_d;
      nrow_q    <= nrow_d;
    end else if (done) begin
      busy_q    <= 1'b0;
    end
  end

  roi_step_cnt #(.CW(CW)) u_col_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .adv_i(busy_q),
    .cnt_i(ncol_q), .idx_o(col_idx), .last_o(col_last)
  );
  roi_step_cnt #(.CW(CW)) u_row_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .adv_i(busy_q && col_last),
    .cnt_i(nrow_q), .idx_o(row_idx), .last_o(row_last)
  );

  logic [COL_W-1:0] col_off;
  logic [ROW_W-1:0] row_off;
  always_comb begin
    col_off = half_q ? COL_W'({col_idx, 1'b0}) : COL_W'(col_idx);
    row_off = half_q ? ROW_W'({row_idx, 1'b0}) : ROW_W'(row_idx);
  end

  assign busy_o      = busy_q;
  assign pix_valid_o = busy_q;
  assign pix_col_o   = org_col_q + col_off;
  assign pix_row_o   = org_row_q + row_off;
  assign sof_o       = busy_q && (col_idx == '0) && (row_idx == '0);
  assign eof_o       = done;
endmodule

// File: rtl/roi_scan_ctrl_chk.sv
module roi_scan_ctrl_chk #(
  parameter int SENSOR_W = 1280,
  parameter int SENSOR_H = 1024,
  parameter int COL_W    = 11,
  parameter int ROW_W    = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             half_scale_i,
  input logic             busy_o,
  input logic             pix_valid_o,
  input logic [ROW_W-1:0] pix_row_o,
  input logic [COL_W-1:0] pix_col_o,
  input logic             sof_o,
  input logic             eof_o
);
  logic cur_half;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cur_half <= 1'b0;
    else if (start_i && !busy_o)    cur_half <= half_scale_i;
  end

  logic [COL_W:0] col_step;
  logic [ROW_W:0] row_step;
  assign col_step = cur_half ? (COL_W+1)'(2) : (COL_W+1)'(1);
  assign row_step = cur_half ? (ROW_W+1)'(2) : (ROW_W+1)'(1);

  assert_no_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !eof_o |=> pix_valid_o);

  assert_col_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !sof_o && (pix_row_o == $past(pix_row_o))
    |-> ({1'b0, pix_col_o} == {1'b0, $past(pix_col_o)} + col_step));

  assert_row_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !sof_o && (pix_row_o != $past(pix_row_o))
    |-> ({1'b0, pix_row_o} == {1'b0, $past(pix_row_o)} + row_step));

  assert_in_sensor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (int'(pix_col_o) < SENSOR_W) && (int'(pix_row_o) < SENSOR_H));

  assert_sof_after_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> $past(start_i && !busy_o));

  assert_idle_after_eof_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !busy_o);

  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !eof_o |=> !sof_o);
endmodule

bind roi_scan_ctrl roi_scan_ctrl_chk #(
  .SENSOR_W(SENSOR_W), .SENSOR_H(SENSOR_H), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .half_scale_i(half_scale_i),
  .busy_o(busy_o), .pix_valid_o(pix_valid_o), .pix_row_o(pix_row_o),
  .pix_col_o(pix_col_o), .sof_o(sof_o), .eof_o(eof_o)
);

// File: tb/roi_scan_ctrl_test.sv
`timescale 1ns/1ps
module roi_scan_ctrl_test;
  localparam int SW = 12;
  localparam int SH = 10;
  localparam int OD = 4;
  localparam int CWB = 4;
  localparam int RWB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CWB-1:0] org_c = '0, win_w = '0;
  logic [RWB-1:0] org_r = '0, win_h = '0;
  logic half = 1'b0;
  logic busy, valid, sof, eof;
  logic [RWB-1:0] prow;
  logic [CWB-1:0] pcol;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  roi_scan_ctrl #(.SENSOR_W(SW), .SENSOR_H(SH), .OUT_DIM(OD), .COL_W(CWB), .ROW_W(RWB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .org_col_i(org_c), .org_row_i(org_r),
    .win_w_i(win_w), .win_h_i(win_h), .half_scale_i(half), .busy_o(busy),
    .pix_valid_o(valid), .pix_row_o(prow), .pix_col_o(pcol), .sof_o(sof), .eof_o(eof)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int kept(input int org, input int len, input int dim, input bit h);
    int ext, k;
    ext = (org >= dim) ? 0 : ((len < dim - org) ? len : dim - org);
    k = h ? (ext + 1) / 2 : ext;
    return (k > OD) ? OD : k;
  endfunction

  // poke >= 0: issue a second, different strobe while showing pixel poke (R8)
  task automatic run_win(input int oc, input int orw, input int w, input int h,
                         input bit hs, input int poke);
    int nc, nr, step, n, cnt;
    nc = kept(oc, w, SW, hs);
    nr = kept(orw, h, SH, hs);
    step = hs ? 2 : 1;
    @(negedge clk);
    org_c = CWB'(oc); org_r = RWB'(orw); win_w = CWB'(w); win_h = RWB'(h); half = hs;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (nc == 0 || nr == 0) begin
      // R9: empty window ignored
      chk(!busy && !valid, "R9", {busy, valid}, 0);
      return;
    end
    n = 0; cnt = 0;
    for (int r = 0; r < nr; r++) begin
      for (int c = 0; c < nc; c++) begin
        bit last, ok;
        last = (r == nr - 1) && (c == nc - 1);
        ok = valid && busy && (int'(pcol) == oc + c * step) && (int'(prow) == orw + r * step);
        // R3 R4 R5 R6 address, R2 continuity
        chk(ok, hs ? "R4" : "R3", {busy, valid, prow, pcol},
            {2'b11, RWB'(orw + r * step), CWB'(oc + c * step)});
        chk(sof == (n == 0) && eof == last, "R7", {sof, eof}, {(n == 0), last});
        if (valid) cnt++;
        if (n == poke) begin
          org_c = '0; org_r = '0; win_w = 4'd2; win_h = 4'd2; half = ~hs; start = 1'b1;
        end else begin
          start = 1'b0;
        end
        n++;
        @(negedge clk);
      end
    end
    start = 1'b0;
    // R8 idle after last pixel, R10 cycle count
    chk(!busy && !valid, "R8", {busy, valid}, 0);
    chk(cnt == nr * nc, "R10", cnt, nr * nc);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !valid && !sof && !eof, "R1", {busy, valid, sof, eof}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !valid && !sof && !eof, "R1", {busy, valid, sof, eof}, 0);

    // directed: single pixel, full clip, poke during busy
    run_win(11, 9, 5, 5, 1'b0, -1);   // R5 clip to 1x1, R7 sof+eof together
    run_win(1, 1, 4, 3, 1'b0, 2);     // R8 strobe while busy ignored
    run_win(2, 3, 7, 7, 1'b1, 0);     // R8 with half scale
    run_win(12, 0, 3, 3, 1'b0, -1);   // R9 origin at edge
    run_win(0, 10, 3, 3, 1'b1, -1);   // R9 row origin at edge

    for (int hs = 0; hs < 2; hs++)
      for (int oc = 0; oc <= SW; oc++)
        for (int wi = 0; wi < 8; wi++)
          for (int ri = 0; ri < 4; ri++)
            for (int hi = 0; hi < 4; hi++) begin
              int w, orw, h;
              w   = (wi == 7) ? 9 : wi;
              orw = (ri == 0) ? 0 : (ri == 1) ? 5 : (ri == 2) ? 9 : 10;
              h   = (hi == 0) ? 0 : (hi == 1) ? 1 : (hi == 2) ? 3 : 9;
              run_win(oc, orw, w, h, hs[0], -1);
            end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule